// File: doc/BRIEF.md
# Segmented Bounds-Checked Address Unit

This unit forms memory addresses for loads and stores that name a segment rather than a base register. A table of sixteen entries holds a base and a size for each segment, and the sizes differ from one segment to the next. Each array placed in a segment begins at offset zero. The offset is compared against the segment size, and the base is then added to it. An access that lands outside its segment raises a trap, and memory is never enabled for it.

A request carries several fields: a mode bit, a segment number, a register operand, an immediate, a shift amount and a two-bit offset-source selector. In logical mode the register operand passes through as the address, and no check is made. The table is loaded through a separate write port. The result appears one clock after the request: a valid flag, the address, a trap flag and a memory enable.

Top module: `seg_addr_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, rsp_valid, rsp_trap, rsp_mem_en and rsp_addr are all zero. Reset also clears every table size to zero.
- R2: When tbl_we is high at a clock edge, the entry at tbl_idx takes tbl_base and tbl_size. A request presented in that same cycle still uses the entry as it was before the write.
- R3: rsp_valid is high exactly one cycle after req_valid was high. A cycle without a request leaves rsp_valid and rsp_mem_en low one cycle later.
- R4: The offset source is chosen by req_src. The code 2'b00 selects req_imm. The code 2'b01 selects req_reg. The codes 2'b10 and 2'b11 select req_reg shifted left by req_shamt, where the shift runs from 0 to 31.
- R5: In segment mode, which is req_seg_mode=1, the address is the segment base plus the offset, taken modulo 2^32.
- R6: A segment access is legal only when the offset, compared unsigned, is strictly below the segment size. An offset equal to the size traps.
- R7: Any access through a segment whose size is zero traps.
- R8: If a shifted offset loses a set bit above bit 31, the access traps, even when the truncated value would lie in range.
- R9: In logical mode, which is req_seg_mode=0, rsp_addr equals req_reg and rsp_trap is low. The segment number, immediate, source and shift have no effect.
- R10: rsp_mem_en is high exactly when rsp_valid is high and rsp_trap is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Segment table write strobe |
| tbl_idx | input | 4 | Table entry to write |
| tbl_base | input | 32 | Base address to store |
| tbl_size | input | 32 | Segment size to store |
| req_valid | input | 1 | Request present |
| req_seg_mode | input | 1 | 1 for segment+offset, 0 for logical address |
| req_seg | input | 4 | Segment number |
| req_src | input | 2 | Offset source selector |
| req_reg | input | 32 | Register operand |
| req_imm | input | 32 | Immediate offset |
| req_shamt | input | 5 | Left shift applied to the register offset |
| rsp_valid | output | 1 | Result valid |
| rsp_addr | output | 32 | Formed address |
| rsp_trap | output | 1 | Out-of-segment trap |
| rsp_mem_en | output | 1 | Memory access enable |

## Verification
A table write and an access to the same segment can fall in the same cycle. Three cases provoke this. In the first, the bench loads a fresh segment while reading it with an offset that the new size would allow; the access must still trap, because the old size is zero. In the second, the bench shrinks a segment to zero while accessing it, and the access must still pass. In the third, mixed traffic writes and reads random entries in the same cycles. A behavioural model applies each write only after it has judged the request of that cycle, and every response is compared against that model on every clock.

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int SEGS = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(SEGS),
  localparam int SW  = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_idx,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] tbl_size,
  input  logic          req_valid,
  input  logic          req_seg_mode,
  input  logic [IW-1:0] req_seg,
  input  logic [1:0]    req_src,
  input  logic [AW-1:0] req_reg,
  input  logic [AW-1:0] req_imm,
  input  logic [SW-1:0] req_shamt,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_trap,
  output logic          rsp_mem_en
);

  logic [AW-1:0] base_q [SEGS];
  logic [AW-1:0] size_q [SEGS];

  logic [2*AW-1:0] shifted;
  logic [AW-1:0]   off;
  logic            shift_ovf;
  logic            seg_trap;
  logic [AW-1:0]   addr_d;

  assign shifted   = {{AW{1'b0}}, req_reg} << req_shamt;
  assign shift_ovf = req_src[1] && (|shifted[2*AW-1:AW]);
  assign off       = (req_src == 2'b00) ? req_imm :
                     (req_src == 2'b01) ? req_reg : shifted[AW-1:0];
  assign seg_trap  = shift_ovf || !(off < size_q[req_seg]);
  assign addr_d    = req_seg_mode ? base_q[req_seg] + off : req_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SEGS; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end
    end else if (tbl_we) begin
      base_q[tbl_idx] <= tbl_base;
      size_q[tbl_idx] <= tbl_size;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_trap   <= 1'b0;
      rsp_mem_en <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_trap   <= req_valid && req_seg_mode && seg_trap;
      rsp_mem_en <= req_valid && !(req_seg_mode && seg_trap);
      if (req_valid) rsp_addr <= addr_d;
    end
  end

endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_seg_mode,
  input logic [AW-1:0] req_reg,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_trap,
  input logic          rsp_mem_en
);

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_mem_en)); // R3
  AST_TRAP_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> !rsp_mem_en); // R10
  AST_MEM_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_mem_en |-> (rsp_valid && !rsp_trap)); // R10
  AST_LOGICAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_seg_mode) |=> (rsp_addr == $past(req_reg) && !rsp_trap)); // R9

endmodule

bind seg_addr_unit seg_addr_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg_mode(req_seg_mode),
  .req_reg(req_reg), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
  .rsp_trap(rsp_trap), .rsp_mem_en(rsp_mem_en)
);

// File: tb/seg_addr_unit_tb.sv
module seg_addr_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [31:0] tbl_base = '0, tbl_size = '0;
  logic        req_valid = 1'b0, req_seg_mode = 1'b0;
  logic [3:0]  req_seg = '0;
  logic [1:0]  req_src = '0;
  logic [31:0] req_reg = '0, req_imm = '0;
  logic [4:0]  req_shamt = '0;
  logic        rsp_valid, rsp_trap, rsp_mem_en;
  logic [31:0] rsp_addr;

  seg_addr_unit u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  longint m_base [16];
  longint m_size [16];
  bit     e_valid, e_trap, e_mem;
  logic [31:0] e_addr;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "valid", rsp_valid, e_valid);
    chk(tag, "trap", rsp_trap, e_trap);
    chk(tag, "mem_en", rsp_mem_en, e_mem);
    if (e_valid) chk(tag, "addr", rsp_addr, e_addr);
  endtask

  // drive at negedge, model judges with pre-write table, compare at next negedge
  task automatic op(string tag, bit v, bit mode, int seg, int src, longint rg, longint imm,
                    int sh, bit we = 0, int widx = 0, longint wb = 0, longint ws = 0);
    longint off, full;
    bit ovf, trap;
    req_valid = v; req_seg_mode = mode; req_seg = 4'(seg); req_src = 2'(src);
    req_reg = 32'(rg); req_imm = 32'(imm); req_shamt = 5'(sh);
    tbl_we = we; tbl_idx = 4'(widx); tbl_base = 32'(wb); tbl_size = 32'(ws);
    full = (rg & 64'hFFFF_FFFF) << sh;
    ovf = (src >= 2) && (full > 64'hFFFF_FFFF);
    off = (src == 0) ? (imm & 64'hFFFF_FFFF) : (src == 1) ? (rg & 64'hFFFF_FFFF)
                                                          : (full & 64'hFFFF_FFFF);
    trap = mode && (ovf || off >= m_size[seg]);
    e_valid = v;
    e_trap = v && trap;
    e_mem = v && !trap;
    e_addr = mode ? 32'(m_base[seg] + off) : 32'(rg);
    if (we) begin m_base[widx] = wb & 64'hFFFF_FFFF; m_size[widx] = ws & 64'hFFFF_FFFF; end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int unsigned s;
    for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_size[i] = 0; end
    repeat (3) @(negedge clk);
    e_valid = 0; e_trap = 0; e_mem = 0; e_addr = 0;
    chk("R1", "addr_in_reset", rsp_addr, 0);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    chk("R1", "addr_after_reset", rsp_addr, 0);
    op("R1_R7", 1, 1, 3, 0, 0, 0, 0);
    op("R2", 1, 1, 2, 0, 0, 4, 0, 1, 2, 32'h1000, 32'h100);
    op("R5", 1, 1, 2, 0, 0, 32'h10, 0);
    op("R6", 1, 1, 2, 0, 0, 32'hFF, 0);
    op("R6", 1, 1, 2, 0, 0, 32'h100, 0);
    op("R4", 1, 1, 2, 1, 32'h40, 32'h7FF, 0);
    op("R4", 1, 1, 2, 2, 3, 0, 4);
    op("R4", 1, 1, 2, 3, 1, 0, 8);
    op("R8", 1, 1, 2, 2, 32'h8000_0001, 0, 1);
    op("R3", 0, 1, 2, 0, 0, 0, 0);
    op("R8", 1, 1, 7, 2, 1, 0, 31, 1, 7, 32'h10, 32'hFFFF_FFFF);
    op("R8", 1, 1, 7, 2, 1, 0, 31);
    op("R5", 1, 1, 9, 0, 0, 32'h20, 0, 1, 9, 32'hFFFF_FFF0, 32'h40);
    op("R5", 1, 1, 9, 0, 0, 32'h20, 0);
    op("R2_R7", 1, 1, 2, 0, 0, 1, 0, 1, 2, 32'h1000, 0);
    op("R7", 1, 1, 2, 0, 0, 0, 0);
    op("R9", 1, 0, 3, 2, 32'hDEAD_0000, 5, 31);
    op("R9", 1, 0, 2, 0, 32'h0000_1234, 32'hFFFF_FFFF, 0);
    op("R3", 0, 0, 0, 0, 0, 0, 0);
    op("R10", 1, 1, 9, 1, 32'h3F, 0, 0);
    s = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      int unsigned a, b, c;
      s = s * 1664525 + 1013904223; a = s;
      s = s * 1664525 + 1013904223; b = s;
      s = s * 1664525 + 1013904223; c = s;
      op("R10", a[0] | a[1], a[2] | a[3], int'(a[7:4]), int'(a[9:8]),
         a[10] ? longint'(b[7:0]) : longint'(b), longint'(c[9:0]), int'(a[15:11]),
         a[16] & a[17], int'(a[21:18]), longint'(c), a[22] ? longint'(b[11:0]) : 0);
    end
    summary();
  end
endmodule